// File: doc/BRIEF.md
# Flash command interface controller

This block is the command decoder and write sequencer of a byte-wide flash memory, built around a small internal array split into equal erase blocks. A host writes commands over an active-low chip-enable, write-enable and output-enable bus. A command is taken when write enable rises while chip enable is low. Commands select what a read returns, clear the error flags, start a timed byte program or block erase, and suspend or resume an erase.

Program and erase each take two bus writes. Once the sequence is accepted, reads return the status byte and `ready_o` goes low. When the timer finishes, the sequencer updates the array. A programming-supply-good input stops work from starting, or aborts work in flight, when the supply is absent. A command-reset input also aborts work in flight. An abort leaves the targeted byte or block only partly changed. The durations are cycle counts set by parameters.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Setup code 40h or 10h, followed by a write of address and data, programs that byte. The byte becomes old AND data exactly PROG_CYCLES clocks after the accepting edge, and `ready_o` is low for those clocks.
- R2: After any setup code (40h, 10h, 20h), after the second write of a sequence, and after 70h, B0h or D0h, reads return the status byte. Reads return array data after FFh, and again after a command reset.
- R3: While a program runs, only 70h has an effect. FFh, 50h and every other code change neither the read mode nor the timing.
- R4: `ready_o` is high exactly when no program or erase timer runs. Status bit 7 carries the same value. The idle status byte is 80h.
- R5: If the data to be programmed has a 1 where the old byte has a 0, status bit 4 (program error) is set when the program completes.
- R6: If the second write of a program or erase arrives while `vpp_ok` is low, status bit 3 is set, no timer starts and the array is left unchanged.
- R7: 20h followed by D0h erases the block chosen by the upper address bits of the D0h write. Its bytes become FFh in ascending order, one every ERASE_STEP clocks. Other blocks are left unchanged.
- R8: If any code other than D0h follows 20h, status bits 5 (erase error) and 4 (program error) are both set, and no erase starts.
- R9: The error bits 5, 4 and 3 stay set until a 50h command is written while idle, or a reset clears them.
- R10: A high `cmd_rst` stops any running operation. An interrupted program leaves old AND (data OR 0Fh). An interrupted erase leaves the already erased leading bytes at FFh and the rest unchanged. `cmd_rst` also clears the status bits and restores array reads.
- R11: If `vpp_ok` falls during a program or erase, the operation stops with the same partial result as R10, and status bit 3 is set. The read mode is kept.
- R12: B0h during an erase suspends it: status bit 6 set and `ready_o` high. Array reads work after FFh. D0h resumes the erase, which then completes in the remaining time.
- R13: `dout` is 00h whenever `ce_n` or `oe_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also fills the array with FFh |
| cmd_rst | input | 1 | Command reset: aborts operations and keeps the array |
| vpp_ok | input | 1 | High when the programming supply is present |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low; a command is taken on its rise |
| oe_n | input | 1 | Output enable, active low |
| addr | input | log2(N_BLOCKS*BLOCK_BYTES) | Byte address; the upper bits select the block |
| din | input | 8 | Command or program data |
| dout | output | 8 | Array byte or status byte |
| ready_o | output | 1 | High when no operation is running |

## Verification
The program path is tried with three kinds of data:
- Data that only clears bits, which must leave no error.
- Data that asks to raise a cleared bit, which must set bit 4 and store the AND.
- Data sent while the supply is low, which must leave the array untouched.

Erases are run to completion, cut short by `cmd_rst`, and suspended and resumed. Comparing the first and last bytes of the block tells a full erase from a partial one. Reading a different block tells a suspended erase from a finished one. A wrong confirm, commands written during busy periods, and the clear command separate the sticky flags from the read-mode switching. A behavioural model compares `dout` and `ready_o` on every clock, which catches any shift by one cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam logic [7:0] CODE_READ_ARRAY = 8'hFF;
    localparam logic [7:0] CODE_READ_STAT  = 8'h70;
    localparam logic [7:0] CODE_CLEAR      = 8'h50;
    localparam logic [7:0] CODE_PROG_A     = 8'h40;
    localparam logic [7:0] CODE_PROG_B     = 8'h10;
    localparam logic [7:0] CODE_ERASE      = 8'h20;
    localparam logic [7:0] CODE_CONFIRM    = 8'hD0;
    localparam logic [7:0] CODE_SUSPEND    = 8'hB0;

    typedef enum logic [2:0] {
        C_READ_ARRAY, C_READ_STAT, C_CLEAR, C_PROG_SETUP,
        C_ERASE_SETUP, C_CONFIRM, C_SUSPEND, C_OTHER
    } cmd_t;

    typedef enum logic [1:0] {WS_IDLE, WS_PROG, WS_ERASE, WS_SUSP} wsm_state_t;
    typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_ERASE} pend_t;

    typedef struct packed {
        logic       ready;
        logic       susp;
        logic       erase_err;
        logic       prog_err;
        logic       vpp_low;
        logic [2:0] rsvd;
    } status_t;

    function automatic cmd_t decode_cmd(input logic [7:0] code);
        case (code)
            CODE_READ_ARRAY:          return C_READ_ARRAY;
            CODE_READ_STAT:           return C_READ_STAT;
            CODE_CLEAR:               return C_CLEAR;
            CODE_PROG_A, CODE_PROG_B: return C_PROG_SETUP;
            CODE_ERASE:               return C_ERASE_SETUP;
            CODE_CONFIRM:             return C_CONFIRM;
            CODE_SUSPEND:             return C_SUSPEND;
            default:                  return C_OTHER;
        endcase
    endfunction

    // programming can only pull bits low
    function automatic logic [7:0] prog_full(input logic [7:0] old_b, input logic [7:0] new_b);
        return old_b & new_b;
    endfunction

    // an interrupted program has only applied its upper nibble
    function automatic logic [7:0] prog_partial(input logic [7:0] old_b, input logic [7:0] new_b);
        return old_b & (new_b | 8'h0F);
    endfunction

    function automatic logic prog_fault(input logic [7:0] old_b, input logic [7:0] new_b);
        return |(new_b & ~old_b);
    endfunction

endpackage

// File: rtl/flash_bus_port.sv
module flash_bus_port (
    input  logic clk,
    input  logic rst,
    input  logic ce_n,
    input  logic we_n,
    input  logic oe_n,
    output logic wr_evt,
    output logic rd_en
);
    logic we_q;

    always_ff @(posedge clk) begin
        if (rst) we_q <= 1'b1;
        else     we_q <= we_n;
    end

    // a write is taken on the rising edge of write enable with the chip selected
    assign wr_evt = !ce_n && we_n && !we_q;
    assign rd_en  = !ce_n && !oe_n;
endmodule

// File: rtl/flash_array.sv
module flash_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [7:0]    rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [7:0]    rdata_b
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/flash_wsm.sv
module flash_wsm
    import flash_cmd_pkg::*;
#(
    parameter int BLK_W       = 4,
    parameter int OFS_W       = 4,
    parameter int BLOCK_BYTES = 16,
    parameter int PROG_CYCLES = 6,
    parameter int ERASE_STEP  = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cmd_rst,
    input  logic                   vpp_ok,
    input  logic                   wr_evt,
    input  cmd_t                   cmd,
    input  logic [BLK_W+OFS_W-1:0] addr,
    input  logic [7:0]             din,
    input  logic [7:0]             old_byte,
    output logic [BLK_W+OFS_W-1:0] prog_addr,
    output status_t                stat,
    output logic                   stat_mode,
    output logic                   ready_o,
    output logic                   mem_we,
    output logic [BLK_W+OFS_W-1:0] mem_waddr,
    output logic [7:0]             mem_wdata
);
    localparam int AW    = BLK_W + OFS_W;
    localparam int MAXC  = (PROG_CYCLES > ERASE_STEP) ? PROG_CYCLES : ERASE_STEP;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [OFS_W-1:0] LAST_OFS = OFS_W'(BLOCK_BYTES - 1);

    wsm_state_t       state;
    pend_t            pend;
    logic [CNT_W-1:0] cnt;
    logic [OFS_W-1:0] ptr;
    logic [BLK_W-1:0] blk;
    logic [AW-1:0]    paddr;
    logic [7:0]       pdata;
    logic             ee, pe, vl;
    logic             halt;
    logic             susp_now;

    assign halt     = cmd_rst || !vpp_ok;
    assign susp_now = wr_evt && (cmd == C_SUSPEND);

    // array write port: program commit or partial, erase byte step
    always_comb begin
        mem_we    = 1'b0;
        mem_waddr = paddr;
        mem_wdata = prog_full(old_byte, pdata);
        if (!rst && state == WS_PROG) begin
            mem_we    = halt || (cnt == '0);
            mem_wdata = halt ? prog_partial(old_byte, pdata) : prog_full(old_byte, pdata);
        end else if (!rst && state == WS_ERASE) begin
            mem_we    = !halt && !susp_now && (cnt == '0);
            mem_waddr = {blk, ptr};
            mem_wdata = 8'hFF;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd_rst) begin
            state     <= WS_IDLE;
            pend      <= PD_NONE;
            stat_mode <= 1'b0;
            ee        <= 1'b0;
            pe        <= 1'b0;
            vl        <= 1'b0;
            cnt       <= '0;
            ptr       <= '0;
            blk       <= '0;
            paddr     <= '0;
            pdata     <= '0;
        end else begin
            case (state)
                WS_PROG: begin
                    if (!vpp_ok) begin
                        vl    <= 1'b1;
                        state <= WS_IDLE;
                    end else begin
                        if (wr_evt && cmd == C_READ_STAT) stat_mode <= 1'b1;
                        if (cnt == '0) begin
                            pe    <= pe | prog_fault(old_byte, pdata);
                            state <= WS_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                WS_ERASE: begin
                    if (!vpp_ok) begin
                        vl    <= 1'b1;
                        state <= WS_IDLE;
                    end else if (susp_now) begin
                        state     <= WS_SUSP;
                        stat_mode <= 1'b1;
                    end else begin
                        if (wr_evt && cmd == C_READ_STAT) stat_mode <= 1'b1;
                        if (cnt == '0) begin
                            if (ptr == LAST_OFS) begin
                                state <= WS_IDLE;
                            end else begin
                                ptr <= ptr + 1'b1;
                                cnt <= CNT_W'(ERASE_STEP - 1);
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                WS_SUSP: begin
                    if (wr_evt) begin
                        case (cmd)
                            C_READ_ARRAY: stat_mode <= 1'b0;
                            C_READ_STAT:  stat_mode <= 1'b1;
                            C_CONFIRM: begin
                                state     <= WS_ERASE;
                                stat_mode <= 1'b1;
                            end
                            default: ;
                        endcase
                    end
                end
                default: begin
                    if (wr_evt) begin
                        case (pend)
                            PD_PROG: begin
                                pend <= PD_NONE;
                                if (!vpp_ok) begin
                                    vl <= 1'b1;
                                end else begin
                                    state <= WS_PROG;
                                    paddr <= addr;
                                    pdata <= din;
                                    cnt   <= CNT_W'(PROG_CYCLES - 1);
                                end
                            end
                            PD_ERASE: begin
                                pend <= PD_NONE;
                                if (cmd != C_CONFIRM) begin
                                    ee <= 1'b1;
                                    pe <= 1'b1;
                                end else if (!vpp_ok) begin
                                    vl <= 1'b1;
                                end else begin
                                    state <= WS_ERASE;
                                    blk   <= addr[AW-1 -: BLK_W];
                                    ptr   <= '0;
                                    cnt   <= CNT_W'(ERASE_STEP - 1);
                                end
                            end
                            default: begin
                                case (cmd)
                                    C_READ_ARRAY: stat_mode <= 1'b0;
                                    C_READ_STAT:  stat_mode <= 1'b1;
                                    C_CLEAR: begin
                                        ee <= 1'b0;
                                        pe <= 1'b0;
                                        vl <= 1'b0;
                                    end
                                    C_PROG_SETUP: begin
                                        pend      <= PD_PROG;
                                        stat_mode <= 1'b1;
                                    end
                                    C_ERASE_SETUP: begin
                                        pend      <= PD_ERASE;
                                        stat_mode <= 1'b1;
                                    end
                                    default: ;
                                endcase
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    assign ready_o   = (state != WS_PROG) && (state != WS_ERASE);
    assign prog_addr = paddr;
    assign stat      = '{ready: ready_o, susp: (state == WS_SUSP), erase_err: ee,
                         prog_err: pe, vpp_low: vl, rsvd: 3'b000};
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int N_BLOCKS    = 16,
    parameter int BLOCK_BYTES = 16,
    parameter int PROG_CYCLES = 6,
    parameter int ERASE_STEP  = 3
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    cmd_rst,
    input  logic                                    vpp_ok,
    input  logic                                    ce_n,
    input  logic                                    we_n,
    input  logic                                    oe_n,
    input  logic [$clog2(N_BLOCKS*BLOCK_BYTES)-1:0] addr,
    input  logic [7:0]                              din,
    output logic [7:0]                              dout,
    output logic                                    ready_o
);
    localparam int BLK_W = $clog2(N_BLOCKS);
    localparam int OFS_W = $clog2(BLOCK_BYTES);
    localparam int AW    = BLK_W + OFS_W;
    localparam int DEPTH = N_BLOCKS * BLOCK_BYTES;

    logic          wr_evt, rd_en;
    cmd_t          cmd;
    status_t       stat;
    logic          stat_mode;
    logic          mem_we;
    logic [AW-1:0] mem_waddr, prog_addr;
    logic [7:0]    mem_wdata, rd_host, rd_old;

    assign cmd = decode_cmd(din);

    flash_bus_port u_bus (
        .clk(clk), .rst(rst), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .wr_evt(wr_evt), .rd_en(rd_en)
    );

    flash_array #(.DEPTH(DEPTH), .AW(AW)) u_array (
        .clk(clk), .rst(rst), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .raddr_a(addr), .rdata_a(rd_host), .raddr_b(prog_addr), .rdata_b(rd_old)
    );

    flash_wsm #(
        .BLK_W(BLK_W), .OFS_W(OFS_W), .BLOCK_BYTES(BLOCK_BYTES),
        .PROG_CYCLES(PROG_CYCLES), .ERASE_STEP(ERASE_STEP)
    ) u_wsm (
        .clk(clk), .rst(rst), .cmd_rst(cmd_rst), .vpp_ok(vpp_ok),
        .wr_evt(wr_evt), .cmd(cmd), .addr(addr), .din(din), .old_byte(rd_old),
        .prog_addr(prog_addr), .stat(stat), .stat_mode(stat_mode), .ready_o(ready_o),
        .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
    );

    assign dout = !rd_en ? 8'h00 : (stat_mode ? stat : rd_host);
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk
    import flash_cmd_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       cmd_rst,
    input logic       vpp_ok,
    input logic       ce_n,
    input logic       oe_n,
    input logic [7:0] dout,
    input logic       ready_o,
    input logic       wr_evt,
    input cmd_t       cmd,
    input status_t    stat,
    input logic       stat_mode,
    input wsm_state_t state,
    input pend_t      pend
);
    // R4
    ready_stat_chk: assert property (@(posedge clk) disable iff (rst)
        (!ce_n && !oe_n && stat_mode) |-> (dout[7] == ready_o));

    // R9
    sticky_err_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.prog_err) |-> ($past(wr_evt && cmd == C_CLEAR) || $past(cmd_rst) || $past(rst)));

    // R12
    susp_ready_chk: assert property (@(posedge clk) disable iff (rst)
        stat.susp |-> ready_o);

    // R6
    vpp_start_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_evt && !vpp_ok && !cmd_rst && state == WS_IDLE && pend == PD_PROG)
            |=> (ready_o && stat.vpp_low));

    // R10
    abort_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rst |=> (ready_o && !stat_mode));

    // R3
    prog_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == WS_PROG && wr_evt && cmd != C_READ_STAT && vpp_ok && !cmd_rst)
            |=> $stable(stat_mode));
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .cmd_rst(cmd_rst), .vpp_ok(vpp_ok), .ce_n(ce_n), .oe_n(oe_n),
    .dout(dout), .ready_o(ready_o), .wr_evt(wr_evt), .cmd(cmd), .stat(stat),
    .stat_mode(stat_mode), .state(u_wsm.state), .pend(u_wsm.pend)
);

// File: tb/flash_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_ctrl_tb_top;
    localparam int PC = 6;
    localparam int ES = 3;
    localparam int BB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_rst = 1'b0;
    logic       vpp_ok = 1'b1;
    logic       ce_n = 1'b1;
    logic       we_n = 1'b1;
    logic       oe_n = 1'b1;
    logic [7:0] addr = 8'h00;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic       ready_o;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_ctrl #(.N_BLOCKS(16), .BLOCK_BYTES(BB), .PROG_CYCLES(PC), .ERASE_STEP(ES)) dut_i (
        .clk(clk), .rst(rst), .cmd_rst(cmd_rst), .vpp_ok(vpp_ok), .ce_n(ce_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .ready_o(ready_o)
    );

    // behavioural reference model; op: 0 none, 1 programming, 2 erasing, 3 suspended
    int m_mem [256];
    int m_op, m_want, m_left, m_idx, m_blk, m_pa, m_pd;
    bit m_smode, m_ee, m_pe, m_vl, m_weq;

    task automatic m_clear();
        m_op = 0; m_want = 0; m_left = 0; m_idx = 0; m_blk = 0; m_pa = 0; m_pd = 0;
        m_smode = 0; m_ee = 0; m_pe = 0; m_vl = 0;
    endtask

    always @(posedge clk) begin
        bit ev;
        int c;
        ev = !ce_n && we_n && !m_weq;
        m_weq = rst ? 1'b1 : we_n;
        c = din;
        if (rst) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 255;
            m_clear();
        end else if (cmd_rst) begin
            if (m_op == 1) m_mem[m_pa] = m_mem[m_pa] & (m_pd | 15);
            m_clear();
        end else if (m_op == 1) begin
            if (!vpp_ok) begin
                m_mem[m_pa] = m_mem[m_pa] & (m_pd | 15); m_vl = 1; m_op = 0;
            end else begin
                if (ev && c == 8'h70) m_smode = 1;
                if (m_left == 0) begin
                    if ((m_pd & ~m_mem[m_pa] & 255) != 0) m_pe = 1;
                    m_mem[m_pa] = m_mem[m_pa] & m_pd; m_op = 0;
                end else m_left--;
            end
        end else if (m_op == 2) begin
            if (!vpp_ok) begin m_vl = 1; m_op = 0; end
            else if (ev && c == 8'hB0) begin m_op = 3; m_smode = 1; end
            else begin
                if (ev && c == 8'h70) m_smode = 1;
                if (m_left == 0) begin
                    m_mem[m_blk * BB + m_idx] = 255;
                    if (m_idx == BB - 1) m_op = 0;
                    else begin m_idx++; m_left = ES - 1; end
                end else m_left--;
            end
        end else if (m_op == 3) begin
            if (ev && c == 8'hFF) m_smode = 0;
            if (ev && c == 8'h70) m_smode = 1;
            if (ev && c == 8'hD0) begin m_op = 2; m_smode = 1; end
        end else if (ev) begin
            if (m_want == 1) begin
                m_want = 0;
                if (!vpp_ok) m_vl = 1;
                else begin m_op = 1; m_pa = addr; m_pd = c; m_left = PC - 1; end
            end else if (m_want == 2) begin
                m_want = 0;
                if (c != 8'hD0) begin m_ee = 1; m_pe = 1; end
                else if (!vpp_ok) m_vl = 1;
                else begin m_op = 2; m_blk = addr / BB; m_idx = 0; m_left = ES - 1; end
            end else begin
                if (c == 8'hFF) m_smode = 0;
                if (c == 8'h70) m_smode = 1;
                if (c == 8'h50) begin m_ee = 0; m_pe = 0; m_vl = 0; end
                if (c == 8'h40 || c == 8'h10) begin m_want = 1; m_smode = 1; end
                if (c == 8'h20) begin m_want = 2; m_smode = 1; end
            end
        end
    end

    function automatic logic [7:0] m_read();
        bit rdy;
        rdy = !(m_op == 1 || m_op == 2);
        if (ce_n || oe_n) return 8'h00;
        if (m_smode) return {rdy, (m_op == 3), m_ee, m_pe, m_vl, 3'b000};
        return 8'(m_mem[addr]);
    endfunction

    always @(negedge clk) begin
        if (!rst && !finished) begin
            n_checks++;
            if (dout !== m_read() || ready_o !== !(m_op == 1 || m_op == 2)) begin
                n_errors++;
                $display("FAIL R2/R4 model t=%0t: dout=%02h ready=%0b expected dout=%02h ready=%0b",
                         $time, dout, ready_o, m_read(), !(m_op == 1 || m_op == 2));
            end
        end
    end

    task automatic step(int n = 1);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        ce_n = 1'b0; addr = a; din = d; we_n = 1'b0;
        step();
        we_n = 1'b1;
        step();
    endtask

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd_chk(string tag, logic [7:0] a, logic [7:0] exp);
        ce_n = 1'b0; addr = a; oe_n = 1'b0;
        #0.5;
        chk(tag, dout, exp);
        oe_n = 1'b1;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        // reset state
        rd_chk("R10 reset array", 8'h00, 8'hFF);
        ce_n = 1'b0; oe_n = 1'b1; #0.5;
        chk("R13 output idle", dout, 8'h00);
        wr(8'h00, 8'h70);
        rd_chk("R4 idle status", 8'h00, 8'h80);

        // program with 40h
        wr(8'h00, 8'h40);
        wr(8'h12, 8'hA5);
        chk("R4 busy pin", {7'd0, ready_o}, 8'h00);
        rd_chk("R2 status while busy", 8'h12, 8'h00);
        wr(8'h00, 8'hFF);
        rd_chk("R3 FFh ignored while programming", 8'h12, 8'h00);
        step(8);
        rd_chk("R4 done status", 8'h12, 8'h80);
        wr(8'h00, 8'hFF);
        rd_chk("R1 programmed byte", 8'h12, 8'hA5);

        // program with 10h raising bits: AND result plus error
        wr(8'h00, 8'h10);
        wr(8'h12, 8'h5A);
        step(8);
        rd_chk("R5 program error", 8'h00, 8'h90);
        wr(8'h00, 8'hFF);
        rd_chk("R1 AND result", 8'h12, 8'h00);
        wr(8'h00, 8'h70);
        rd_chk("R9 error sticky", 8'h00, 8'h90);
        wr(8'h00, 8'h50);
        rd_chk("R9 cleared", 8'h00, 8'h80);

        // supply low at start
        vpp_ok = 1'b0;
        wr(8'h00, 8'h40);
        wr(8'h20, 8'h00);
        chk("R6 no busy", {7'd0, ready_o}, 8'h01);
        rd_chk("R6 vpp status", 8'h00, 8'h88);
        vpp_ok = 1'b1;
        wr(8'h00, 8'hFF);
        rd_chk("R6 array unchanged", 8'h20, 8'hFF);
        wr(8'h00, 8'h50);

        // other-block data, then erase block 1
        wr(8'h00, 8'h40); wr(8'h25, 8'h3C); step(8);
        wr(8'h00, 8'h40); wr(8'h50, 8'h77); step(8);
        wr(8'h15, 8'h20);
        wr(8'h1A, 8'hD0);
        step(BB * ES + 4);
        rd_chk("R7 erase status", 8'h00, 8'h80);
        wr(8'h00, 8'hFF);
        rd_chk("R7 erased byte", 8'h12, 8'hFF);
        rd_chk("R7 other block kept", 8'h25, 8'h3C);

        // bad confirm
        wr(8'h00, 8'h20);
        wr(8'h00, 8'h70);
        rd_chk("R8 bad confirm", 8'h00, 8'hB0);
        wr(8'h00, 8'h50);

        // command reset during program
        wr(8'h00, 8'h40);
        wr(8'h30, 8'h00);
        step(2);
        cmd_rst = 1'b1; step(); cmd_rst = 1'b0;
        chk("R10 ready after abort", {7'd0, ready_o}, 8'h01);
        rd_chk("R10 partial program", 8'h30, 8'h0F);

        // command reset during erase of block 3
        wr(8'h00, 8'h40); wr(8'h3F, 8'h00); step(8);
        wr(8'h30, 8'h20);
        wr(8'h30, 8'hD0);
        step(10);
        cmd_rst = 1'b1; step(); cmd_rst = 1'b0;
        rd_chk("R10 leading byte erased", 8'h30, 8'hFF);
        rd_chk("R10 trailing byte kept", 8'h3F, 8'h00);

        // supply drop during program
        wr(8'h00, 8'h40);
        wr(8'h40, 8'h00);
        step(2);
        vpp_ok = 1'b0; step(); vpp_ok = 1'b1;
        rd_chk("R11 vpp abort status", 8'h00, 8'h88);
        wr(8'h00, 8'hFF);
        rd_chk("R11 partial program", 8'h40, 8'h0F);
        wr(8'h00, 8'h50);

        // suspend and resume erase of block 2
        wr(8'h20, 8'h20);
        wr(8'h20, 8'hD0);
        step(4);
        wr(8'h00, 8'hB0);
        rd_chk("R12 suspended status", 8'h00, 8'hC0);
        wr(8'h00, 8'hFF);
        rd_chk("R12 read other block", 8'h50, 8'h77);
        rd_chk("R12 unerased byte kept", 8'h25, 8'h3C);
        step(BB * ES + 4);
        wr(8'h00, 8'h70);
        rd_chk("R12 still suspended", 8'h00, 8'hC0);
        wr(8'h00, 8'hD0);
        chk("R12 resumed busy", {7'd0, ready_o}, 8'h00);
        step(BB * ES + 4);
        rd_chk("R12 resumed done", 8'h00, 8'h80);
        wr(8'h00, 8'hFF);
        rd_chk("R12 erase completed", 8'h25, 8'hFF);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL R4 watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    end
endmodule